// File: doc/BRIEF.md
# Serial Memory Device-Select Decoder

This block is the bus-facing front end of a two-wire serial memory slave. It oversamples the clock and data lines of the bus with the system clock. It recognises Start and Stop conditions and collects the first byte that follows every Start. That byte is the device-select word. Its upper nibble names the device type, the next three bits must equal three strap pins, and the lowest bit gives the transfer direction.

Two device-type codes are decoded. One selects the main storage array and the other selects a separate read-only identification area. When the word matches and the write engine is idle, the block acknowledges by pulling the data line low for the ninth clock. It then holds a selection that reports the space and the direction until the next Start or Stop. In every other case it falls back to standby and ignores the bus until a new Start. Because the busy input blocks the acknowledge, a master can poll with repeated select words until an internal write cycle has finished.

Top module: `eds_dev_select`

## Requirements
- R1: A Start (data falling while the clock is high) begins reception of a new select word. A Stop (data rising while the clock is high) returns the block to standby with `sel_valid` low.
- R2: A device-type nibble (word bits 7:4) of 1010 selects the main array, reported as `sel_space` = 0.
- R3: A device-type nibble of 1011 selects the identification area, reported as `sel_space` = 1.
- R4: Any other device-type nibble gives no acknowledge and no selection.
- R5: Word bits 3:1 must equal `strap_sel[2:0]` bit for bit, or there is no acknowledge.
- R6: Word bit 0 gives the direction: 1 means read (`sel_read` = 1) and 0 means write. `sel_space` and `sel_read` stay stable while the selection is held.
- R7: On a match, `sda_pull` rises after the clock falling edge that ends the eighth bit, so it is high while the clock is high in the ninth bit. It falls after the falling edge that ends the ninth bit, and at that point `sel_valid` is high.
- R8: After a word that does not match, the block ignores all further bits until the next Start and never pulls the data line.
- R9: If `wr_busy` is high when the eighth bit completes, the block gives no acknowledge. Once `wr_busy` is low, a new Start with a matching word is acknowledged again.
- R10: `sel_write_en` is high only for a held selection of the main array in the write direction. A write-direction word to the identification area is acknowledged (it is a pointer-setting dummy write), but `sel_write_en` stays low.
- R11: A repeated Start in the middle of a select word discards the bits received so far and restarts reception.
- R12: After reset, `sda_pull`, `sel_valid` and `sel_write_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_sel | input | 3 | Hard-wired chip-select strap pins |
| wr_busy | input | 1 | High while the internal write cycle runs |
| sda_pull | output | 1 | Open-drain pull-low enable for the data line |
| sel_valid | output | 1 | Device is selected (acknowledge in progress or given) |
| sel_space | output | 1 | 0 = main array, 1 = identification area |
| sel_read | output | 1 | 1 = read transfer, 0 = write transfer |
| sel_write_en | output | 1 | Selection allows a write into the main array |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, three strap bits, and type codes 1010 and 1011. With these settings every meaningful select word can be reached by table entries: both space codes in both directions, foreign type nibbles, strap mismatches in single bits, and the busy-blocked case. Directed sequences cover the acknowledge window edges, bits that follow a rejected word, recovery from busy, and a repeated Start in the middle of a word.

// File: rtl/eds_pkg.sv
package eds_pkg;

  localparam int unsigned WORD_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACK  = 2'd2,
    ST_SEL  = 2'd3
  } eds_state_e;

  typedef enum logic {
    SPACE_MAIN   = 1'b0,
    SPACE_SERIAL = 1'b1
  } eds_space_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } eds_bus_ev_t;

endpackage

// File: rtl/eds_line_sync.sv
module eds_line_sync
  import eds_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output eds_bus_ev_t ev
);

  logic [SYNC_STAGES-1:0] scl_chain_q, scl_chain_d;
  logic [SYNC_STAGES-1:0] sda_chain_q, sda_chain_d;
  logic scl_prev_q, sda_prev_q;
  logic scl_s, sda_s;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_comb begin
        scl_chain_d = scl_in;
        sda_chain_d = sda_in;
      end
    end else begin : g_multi
      always_comb begin
        scl_chain_d = {scl_chain_q[SYNC_STAGES-2:0], scl_in};
        sda_chain_d = {sda_chain_q[SYNC_STAGES-2:0], sda_in};
      end
    end
  endgenerate

  assign scl_s = scl_chain_q[SYNC_STAGES-1];
  assign sda_s = sda_chain_q[SYNC_STAGES-1];

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain_q <= '1;
      sda_chain_q <= '1;
      scl_prev_q  <= 1'b1;
      sda_prev_q  <= 1'b1;
    end else begin
      scl_chain_q <= scl_chain_d;
      sda_chain_q <= sda_chain_d;
      scl_prev_q  <= scl_s;
      sda_prev_q  <= sda_s;
    end
  end

  always_comb begin
    ev.start    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    ev.stop     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
    ev.scl_rise = scl_s & ~scl_prev_q;
    ev.scl_fall = ~scl_s & scl_prev_q;
    ev.sda      = sda_s;
  end

endmodule

// File: rtl/eds_shifter.sv
module eds_shifter #(
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned CNT_W = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [WORD_BITS-1:0] word,
  output logic                 full
);

  logic [WORD_BITS-1:0] word_q, word_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;

  assign full = (cnt_q == CNT_W'(WORD_BITS));
  assign word = word_q;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (shift_en && !full) begin
      word_d = {word_q[WORD_BITS-2:0], bit_in};
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/eds_match.sv
module eds_match
  import eds_pkg::*;
#(
  parameter int unsigned WBITS       = 8,
  parameter int unsigned SEL_BITS    = 3,
  parameter int unsigned MAIN_CODE   = 10,
  parameter int unsigned SERIAL_CODE = 11,
  localparam int unsigned TYPE_W = WBITS - SEL_BITS - 1
) (
  input  logic [WBITS-1:0]    word,
  input  logic [SEL_BITS-1:0] strap,
  output logic                hit,
  output eds_space_e          space,
  output logic                rd
);

  logic [TYPE_W-1:0]   type_f;
  logic [SEL_BITS-1:0] sel_f;
  logic is_main, is_serial, sel_ok;

  always_comb begin
    type_f    = word[WBITS-1 -: TYPE_W];
    sel_f     = word[SEL_BITS:1];
    is_main   = (type_f == TYPE_W'(MAIN_CODE));
    is_serial = (type_f == TYPE_W'(SERIAL_CODE));
    sel_ok    = (sel_f == strap);
    hit       = (is_main | is_serial) & sel_ok;
    space     = is_serial ? SPACE_SERIAL : SPACE_MAIN;
    rd        = word[0];
  end

endmodule

// File: rtl/eds_dev_select.sv
module eds_dev_select
  import eds_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_BITS    = 3,
  parameter int unsigned MAIN_CODE   = 10,
  parameter int unsigned SERIAL_CODE = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  input  logic [SEL_BITS-1:0] strap_sel,
  input  logic                wr_busy,
  output logic                sda_pull,
  output logic                sel_valid,
  output logic                sel_space,
  output logic                sel_read,
  output logic                sel_write_en
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  eds_bus_ev_t ev;

  eds_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .ev     (ev)
  );

  logic                 sh_clear, sh_shift, sh_full;
  logic [WORD_BITS-1:0] sh_word;

  eds_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (sh_clear),
    .shift_en (sh_shift),
    .bit_in   (ev.sda),
    .word     (sh_word),
    .full     (sh_full)
  );

  logic       m_hit, m_rd;
  eds_space_e m_space;

  eds_match #(
    .WBITS       (WORD_BITS),
    .SEL_BITS    (SEL_BITS),
    .MAIN_CODE   (MAIN_CODE),
    .SERIAL_CODE (SERIAL_CODE)
  ) u_match (
    .word  (sh_word),
    .strap (strap_sel),
    .hit   (m_hit),
    .space (m_space),
    .rd    (m_rd)
  );

  eds_state_e state_q, state_d;
  eds_space_e space_q;
  logic       rd_q;
  logic       latch_en;

  always_comb begin
    state_d  = state_q;
    sh_clear = 1'b0;
    sh_shift = 1'b0;
    latch_en = 1'b0;
    if (ev.start) begin
      state_d  = ST_ADDR;
      sh_clear = 1'b1;
    end else if (ev.stop) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          sh_shift = ev.scl_rise;
          if (ev.scl_fall && sh_full) begin
            if (m_hit && !wr_busy) begin
              state_d  = ST_ACK;
              latch_en = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (ev.scl_fall) state_d = ST_SEL;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      space_q <= SPACE_MAIN;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (latch_en) begin
        space_q <= m_space;
        rd_q    <= m_rd;
      end
    end
  end

  assign sda_pull     = (state_q == ST_ACK);
  assign sel_valid    = (state_q == ST_ACK) || (state_q == ST_SEL);
  assign sel_space    = space_q;
  assign sel_read     = rd_q;
  assign sel_write_en = sel_valid && (space_q == SPACE_MAIN) && !rd_q;

endmodule

// File: rtl/eds_checker.sv
module eds_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_busy,
  input logic sda_pull,
  input logic sel_valid,
  input logic sel_space,
  input logic sel_read,
  input logic sel_write_en
);

  AST_PULL_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> sel_valid); // R7

  AST_SELECT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_valid) |-> sda_pull); // R7

  AST_BUSY_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(wr_busy)); // R9

  AST_WRITE_MAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_write_en |-> (sel_valid && !sel_space && !sel_read)); // R10

  AST_SELECT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && $past(sel_valid)) |-> ($stable(sel_space) && $stable(sel_read))); // R6

endmodule

bind eds_dev_select eds_checker u_eds_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_busy      (wr_busy),
  .sda_pull     (sda_pull),
  .sel_valid    (sel_valid),
  .sel_space    (sel_space),
  .sel_read     (sel_read),
  .sel_write_en (sel_write_en)
);

// File: tb/eds_dev_select_bench.sv
module eds_dev_select_bench;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic [2:0] strap;
  logic       busy;
  logic       sda_pull, sel_valid, sel_space, sel_read, sel_write_en;
  logic       sda_bus;

  int n_tests = 0;
  int n_fail  = 0;
  logic ack_seen;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  eds_dev_select u_eds_dev_select (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_m),
    .sda_in       (sda_bus),
    .strap_sel    (strap),
    .wr_busy      (busy),
    .sda_pull     (sda_pull),
    .sel_valid    (sel_valid),
    .sel_space    (sel_space),
    .sel_read     (sel_read),
    .sel_write_en (sel_write_en)
  );

  // vector: addr, strap, busy, exp_ack, exp_space, exp_read, exp_wen
  typedef struct packed {
    logic [7:0] addr;
    logic [2:0] strap;
    logic       busy;
    logic       ack;
    logic       space;
    logic       rd;
    logic       wen;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'b1010_101_0, 3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 main write
    '{8'b1010_101_1, 3'b101, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 R6 main read
    '{8'b1011_101_1, 3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 serial read
    '{8'b1011_101_0, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 serial dummy write
    '{8'b1100_101_0, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 foreign type
    '{8'b1010_100_0, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 strap mismatch
    '{8'b1010_011_1, 3'b011, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 other strap
    '{8'b1010_101_0, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 busy
    '{8'b0010_101_0, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 foreign type
    '{8'b1011_000_1, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}  // R3 serial, zero strap
  };

  task automatic chk(input logic cond, input string req, input logic act, input logic exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(4);
    scl_m = 1'b1; wait_cyc(8);
    sda_m = 1'b0; wait_cyc(8);
    scl_m = 1'b0; wait_cyc(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(4);
    scl_m = 1'b1; wait_cyc(8);
    sda_m = 1'b1; wait_cyc(8);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wait_cyc(4);
    scl_m = 1'b1; wait_cyc(8);
    scl_m = 1'b0; wait_cyc(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic ack_bit();
    sda_m = 1'b1; wait_cyc(4);
    scl_m = 1'b1; wait_cyc(4);
    ack_seen = sda_pull;
    wait_cyc(4);
    scl_m = 1'b0; wait_cyc(6);
  endtask

  initial begin
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    strap = 3'b101;
    busy  = 1'b0;
    ack_seen = 1'b0;
    wait_cyc(5);
    // R12 reset state
    chk(sda_pull == 1'b0, "R12 pull", sda_pull, 1'b0);
    chk(sel_valid == 1'b0, "R12 valid", sel_valid, 1'b0);
    chk(sel_write_en == 1'b0, "R12 wen", sel_write_en, 1'b0);
    rst_n = 1'b1;
    wait_cyc(6);

    for (int k = 0; k < NV; k++) begin
      strap = VEC[k].strap;
      busy  = VEC[k].busy;
      wait_cyc(2);
      bus_start();
      send_byte(VEC[k].addr);
      ack_bit();
      chk(ack_seen == VEC[k].ack, "R7/R4/R5/R9 ack", ack_seen, VEC[k].ack);
      chk(sda_pull == 1'b0, "R7 release", sda_pull, 1'b0);
      chk(sel_valid == VEC[k].ack, "R4/R5 valid", sel_valid, VEC[k].ack);
      if (VEC[k].ack) begin
        chk(sel_space == VEC[k].space, "R2/R3 space", sel_space, VEC[k].space);
        chk(sel_read == VEC[k].rd, "R6 direction", sel_read, VEC[k].rd);
        chk(sel_write_en == VEC[k].wen, "R10 wen", sel_write_en, VEC[k].wen);
      end
      bus_stop();
      chk(sel_valid == 1'b0, "R1 stop", sel_valid, 1'b0);
      busy = 1'b0;
    end

    // R7: no pull during the eighth bit, pull during the ninth
    strap = 3'b101;
    bus_start();
    for (int i = 7; i >= 1; i--) send_bit(1'(8'hAA >> i));
    sda_m = 1'b0; wait_cyc(4);
    scl_m = 1'b1; wait_cyc(4);
    chk(sda_pull == 1'b0, "R7 early", sda_pull, 1'b0);
    wait_cyc(4);
    scl_m = 1'b0; wait_cyc(4);
    ack_bit();
    chk(ack_seen == 1'b1, "R7 ninth", ack_seen, 1'b1);
    bus_stop();

    // R8: bits after a rejected word are ignored
    bus_start();
    send_byte(8'b1010_000_0);
    ack_bit();
    chk(ack_seen == 1'b0, "R8 reject", ack_seen, 1'b0);
    send_byte(8'b1010_101_0);
    ack_bit();
    chk(ack_seen == 1'b0, "R8 ignored", ack_seen, 1'b0);
    chk(sel_valid == 1'b0, "R8 valid", sel_valid, 1'b0);
    bus_stop();

    // R9: polling while busy, then acknowledged once idle
    busy = 1'b1;
    bus_start();
    send_byte(8'b1010_101_1);
    ack_bit();
    chk(ack_seen == 1'b0, "R9 busy poll", ack_seen, 1'b0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(8'b1010_101_1);
    ack_bit();
    chk(ack_seen == 1'b1, "R9 idle poll", ack_seen, 1'b1);
    bus_stop();

    // R11: repeated start mid-word
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'b1011_101_1);
    ack_bit();
    chk(ack_seen == 1'b1, "R11 restart ack", ack_seen, 1'b1);
    chk(sel_space == 1'b1, "R11 space", sel_space, 1'b1);
    // R1: a start while selected drops the selection
    bus_start();
    chk(sel_valid == 1'b0, "R1 start drops", sel_valid, 1'b0);
    bus_stop();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule